// File: doc/BRIEF.md
# USB Transmit Endpoint Control

This block holds the control and status word for one device-side IN endpoint and runs the packet sequencing behind it. A CPU writes and reads a 16-bit word. The FIFO side reports how many bytes sit in the buffer being loaded, together with the configured maximum packet size. The protocol side delivers IN tokens and reports when a data packet has gone out, when an ACK came back and when a STALL was sent.

In reply to each IN token, the block chooses the handshake or packet: data, NAK, STALL or a zero-length packet. It counts how many packets are queued across one or two buffers. It tells the FIFO side when to release a packet or reset its pointer. It keeps the data toggle, and it raises a one-cycle interrupt whenever a queued packet is retired by transmission.

Top module: `usb_txep_ctrl`

## Requirements
- R1: After reset every readable bit of `csr_rdata` is 0, and `resp_valid`, `pkt_release`, `fifo_flush` and `irq` are 0.
- R2: Writing 1 to bit 0 queues one packet if fewer than NBUF are queued. Writing 0 to bit 0 has no effect. Bit 1 reads 1 while at least one packet is queued. Bit 0 reads 1 only while NBUF packets are queued. The default NBUF is 2.
- R3: With bit 15 set, one packet is queued on the first cycle in which `fifo_byte_cnt` equals a nonzero `max_pkt_size`. A byte count that stays equal queues nothing more.
- R4: One cycle after `in_token`, `resp_valid` pulses. `resp_kind` gives the answer (0 data, 1 NAK, 2 STALL, 3 zero-length) and `resp_odd` gives the current data toggle.
- R5: An IN token that finds no queued packet and no active stall sets bit 2. The answer is NAK with bit 14 clear, or a zero-length packet with bit 14 set. Writing 0 to bit 2 clears it. Writing 1 to bit 2 does not change it.
- R6: With bits 14 and 11 clear, `ack_rcvd` retires one queued packet, flips the toggle and pulses `pkt_release`. `pkt_sent` alone leaves the packet queued.
- R7: With bit 14 set, `pkt_sent` retires a packet and leaves the toggle unchanged. `ack_rcvd` is ignored.
- R8: With bit 11 set and bit 14 clear, `pkt_sent` retires a packet and flips the toggle. A later `ack_rcvd` is ignored.
- R9: `irq` pulses one cycle after a packet is retired, but only while `irq_en` is 1.
- R10: Writing 1 to bit 3 while a packet is queued drops one packet and pulses `fifo_flush`. With nothing queued it does nothing. Bits 3 and 6 always read 0.
- R11: While bit 4 is 1, IN tokens get a STALL answer, unless bit 14 is set, in which case bit 4 is ignored.
- R12: `stall_sent` sets bit 5, drops every queued packet and pulses `fifo_flush`. Writing 0 to bit 5 clears it.
- R13: Writing 1 to bit 6 resets the toggle to 0. This takes priority over a flip in the same cycle.
- R14: Bits 15 to 10 read back the last value written. Bits 9 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Control word write strobe |
| csr_wdata | input | 16 | Control word write data |
| csr_rdata | output | 16 | Control word read value |
| fifo_byte_cnt | input | CNT_W | Bytes loaded in the buffer being filled |
| max_pkt_size | input | CNT_W | Configured maximum packet size |
| irq_en | input | 1 | Interrupt enable |
| in_token | input | 1 | IN token received (pulse) |
| pkt_sent | input | 1 | Data packet transmitted (pulse) |
| ack_rcvd | input | 1 | ACK received from host (pulse) |
| stall_sent | input | 1 | STALL handshake transmitted (pulse) |
| resp_valid | output | 1 | Answer to the last IN token is valid |
| resp_kind | output | 2 | 0 data, 1 NAK, 2 STALL, 3 zero-length |
| resp_odd | output | 1 | Data toggle for the answer |
| pkt_release | output | 1 | Drop the oldest packet from the FIFO |
| fifo_flush | output | 1 | Reset the FIFO pointer for the next packet |
| irq | output | 1 | Packet-retired interrupt pulse |

## Verification
A wrong queue count shows up on bits 1 and 0 of the read word in the cycle right after the event that changed it. It also shows up on the next IN answer, which becomes NAK or zero-length instead of data. A wrong toggle stays hidden until the next data answer, where `resp_odd` exposes it. That is why the vectors follow every retire with an IN token. A stuck underrun or stall-sent flag is seen on the read word directly after the clearing write.

// File: rtl/usb_txep_pkg.sv
package usb_txep_pkg;

    typedef enum logic [1:0] {
        RESP_DATA  = 2'd0,
        RESP_NAK   = 2'd1,
        RESP_STALL = 2'd2,
        RESP_ZLP   = 2'd3
    } resp_kind_e;

    localparam int B_RDY    = 0;
    localparam int B_NEMPTY = 1;
    localparam int B_UNDER  = 2;
    localparam int B_FLUSH  = 3;
    localparam int B_STALL  = 4;
    localparam int B_STSENT = 5;
    localparam int B_CLRTOG = 6;
    localparam int B_DMAMD  = 10;
    localparam int B_FRCTOG = 11;
    localparam int B_DMAEN  = 12;
    localparam int B_DIR    = 13;
    localparam int B_ISO    = 14;
    localparam int B_AUTO   = 15;

    typedef struct packed {
        logic       autoset;
        logic       iso;
        logic       dir_tx;
        logic       dma_en;
        logic       frc_tog;
        logic       dma_mode;
        logic       stall_done;
        logic       stall_req;
        logic       underrun;
        logic       toggle;
        logic       match_prev;
        logic       resp_valid;
        resp_kind_e resp_kind;
        logic       resp_odd;
        logic       release_p;
        logic       flush_p;
        logic       irq_p;
    } ep_state_t;

endpackage

// File: rtl/usb_txep_occ.sv
module usb_txep_occ #(
    parameter int NBUF  = 2,
    localparam int OCC_W = $clog2(NBUF + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             take,
    input  logic             clear_all,
    output logic [OCC_W-1:0] occ,
    output logic             full,
    output logic             nonempty
);
    logic [OCC_W-1:0] occ_d, occ_q;
    logic             can_arm, can_take;

    always_comb begin
        can_arm  = arm && (occ_q < OCC_W'(NBUF));
        can_take = take && (occ_q != '0);
        occ_d    = occ_q;
        if (clear_all)
            occ_d = '0;
        else if (can_arm && !can_take)
            occ_d = occ_q + 1'b1;
        else if (!can_arm && can_take)
            occ_d = occ_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) occ_q <= '0;
        else        occ_q <= occ_d;
    end

    assign occ      = occ_q;
    assign full     = (occ_q == OCC_W'(NBUF));
    assign nonempty = (occ_q != '0);

    // R2: queue count never exceeds the number of buffers
    a_r2_occ_range: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OCC_W'(NBUF));
    // R12: a sent stall empties the queue
    a_r12_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear_all |=> occ_q == '0);
endmodule

// File: rtl/usb_txep_resp.sv
module usb_txep_resp
    import usb_txep_pkg::*;
(
    input  logic       stall_req,
    input  logic       iso,
    input  logic       have_pkt,
    output resp_kind_e kind,
    output logic       starved
);
    always_comb begin
        starved = 1'b0;
        if (stall_req && !iso) begin
            kind = RESP_STALL;
        end else if (have_pkt) begin
            kind = RESP_DATA;
        end else begin
            starved = 1'b1;
            kind    = iso ? RESP_ZLP : RESP_NAK;
        end
    end
endmodule

// File: rtl/usb_txep_ctrl.sv
module usb_txep_ctrl
    import usb_txep_pkg::*;
#(
    parameter int CNT_W = 11,
    parameter int NBUF  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             csr_wr,
    input  logic [15:0]      csr_wdata,
    output logic [15:0]      csr_rdata,
    input  logic [CNT_W-1:0] fifo_byte_cnt,
    input  logic [CNT_W-1:0] max_pkt_size,
    input  logic             irq_en,
    input  logic             in_token,
    input  logic             pkt_sent,
    input  logic             ack_rcvd,
    input  logic             stall_sent,
    output logic             resp_valid,
    output logic [1:0]       resp_kind,
    output logic             resp_odd,
    output logic             pkt_release,
    output logic             fifo_flush,
    output logic             irq
);
    localparam int OCC_W = $clog2(NBUF + 1);

    ep_state_t        st_d, st_q;
    logic [OCC_W-1:0] occ;
    logic             q_full, q_nonempty;
    logic             size_hit, arm, retire, flush_wr, take;
    resp_kind_e       kind_w;
    logic             starved;

    usb_txep_occ #(.NBUF(NBUF)) u_occ (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .take      (take),
        .clear_all (stall_sent),
        .occ       (occ),
        .full      (q_full),
        .nonempty  (q_nonempty)
    );

    usb_txep_resp u_resp (
        .stall_req (st_q.stall_req),
        .iso       (st_q.iso),
        .have_pkt  (q_nonempty),
        .kind      (kind_w),
        .starved   (starved)
    );

    always_comb begin
        size_hit = st_q.autoset && (max_pkt_size != '0) && (fifo_byte_cnt == max_pkt_size);
        arm      = (csr_wr && csr_wdata[B_RDY]) || (size_hit && !st_q.match_prev);
        retire   = q_nonempty &&
                   ((pkt_sent && (st_q.iso || st_q.frc_tog)) ||
                    (ack_rcvd && !st_q.iso && !st_q.frc_tog));
        flush_wr = csr_wr && csr_wdata[B_FLUSH] && q_nonempty;
        take     = retire || flush_wr;

        st_d            = st_q;
        st_d.match_prev = size_hit;
        if (csr_wr) begin
            st_d.autoset    = csr_wdata[B_AUTO];
            st_d.iso        = csr_wdata[B_ISO];
            st_d.dir_tx     = csr_wdata[B_DIR];
            st_d.dma_en     = csr_wdata[B_DMAEN];
            st_d.frc_tog    = csr_wdata[B_FRCTOG];
            st_d.dma_mode   = csr_wdata[B_DMAMD];
            st_d.stall_req  = csr_wdata[B_STALL];
            st_d.underrun   = st_q.underrun & csr_wdata[B_UNDER];
            st_d.stall_done = st_q.stall_done & csr_wdata[B_STSENT];
        end
        if (in_token && starved) st_d.underrun   = 1'b1;
        if (stall_sent)          st_d.stall_done = 1'b1;

        if (csr_wr && csr_wdata[B_CLRTOG])
            st_d.toggle = 1'b0;
        else if (retire && !st_q.iso)
            st_d.toggle = !st_q.toggle;

        st_d.resp_valid = in_token;
        st_d.resp_kind  = in_token ? kind_w : RESP_DATA;
        st_d.resp_odd   = in_token ? st_q.toggle : 1'b0;
        st_d.release_p  = retire;
        st_d.flush_p    = flush_wr || stall_sent;
        st_d.irq_p      = retire && irq_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign csr_rdata = {st_q.autoset, st_q.iso, st_q.dir_tx, st_q.dma_en,
                        st_q.frc_tog, st_q.dma_mode, 3'b000, 1'b0,
                        st_q.stall_done, st_q.stall_req, 1'b0, st_q.underrun,
                        q_nonempty, q_full};
    assign resp_valid  = st_q.resp_valid;
    assign resp_kind   = st_q.resp_kind;
    assign resp_odd    = st_q.resp_odd;
    assign pkt_release = st_q.release_p;
    assign fifo_flush  = st_q.flush_p;
    assign irq         = st_q.irq_p;

    // R4: an answer only follows an IN token
    a_r4_resp_after_token: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> $past(in_token));
    // R5: a starved, unstalled IN token leaves the underrun flag set
    a_r5_underrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (in_token && !q_nonempty && !(st_q.stall_req && !st_q.iso)) |=> csr_rdata[B_UNDER]);
    // R9: interrupt only when enabled
    a_r9_irq_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(irq_en));
    // R10: flush request on an empty queue pulses nothing
    a_r10_idle_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_wdata[B_FLUSH] && !q_nonempty && !stall_sent) |=> !fifo_flush);
    // R12: stall sent sets the flag and flushes
    a_r12_stall_flush: assert property (@(posedge clk) disable iff (!rst_n)
        stall_sent |=> (fifo_flush && csr_rdata[B_STSENT] && csr_rdata[1:0] == 2'b00));
    // R13: toggle reset wins
    a_r13_clr_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_wr && csr_wdata[B_CLRTOG]) |=> !st_q.toggle);
endmodule

// File: tb/sim_usb_txep_ctrl.sv
module sim_usb_txep_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        csr_wr = 1'b0;
    logic [15:0] csr_wdata = '0;
    logic [15:0] csr_rdata;
    logic [10:0] fifo_byte_cnt = '0;
    logic [10:0] max_pkt_size = 11'd64;
    logic        irq_en = 1'b1;
    logic        in_token = 1'b0, pkt_sent = 1'b0, ack_rcvd = 1'b0, stall_sent = 1'b0;
    logic        resp_valid, resp_odd, pkt_release, fifo_flush, irq;
    logic [1:0]  resp_kind;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    usb_txep_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .fifo_byte_cnt(fifo_byte_cnt),
        .max_pkt_size(max_pkt_size), .irq_en(irq_en), .in_token(in_token),
        .pkt_sent(pkt_sent), .ack_rcvd(ack_rcvd), .stall_sent(stall_sent),
        .resp_valid(resp_valid), .resp_kind(resp_kind), .resp_odd(resp_odd),
        .pkt_release(pkt_release), .fifo_flush(fifo_flush), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic [15:0] wd;
        logic        tok, snt, ack, stl;
        logic [15:0] rd;
        logic        rv;
        logic [1:0]  rk;
        logic        ro, rel, fl, iq;
    } vec_t;

    localparam int NV = 38;
    localparam vec_t VEC [NV] = '{
        '{1'b1,16'h0001,1'b0,1'b0,1'b0,1'b0,16'h0002,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R2
        '{1'b1,16'h0001,1'b0,1'b0,1'b0,1'b0,16'h0003,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R2
        '{1'b1,16'h0001,1'b0,1'b0,1'b0,1'b0,16'h0003,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R2 full
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,16'h0003,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0}, // R4
        '{1'b0,16'h0000,1'b0,1'b1,1'b0,1'b0,16'h0003,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R6
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,1'b0,16'h0002,1'b0,2'd0,1'b0,1'b1,1'b0,1'b1}, // R6 R9
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,16'h0002,1'b1,2'd0,1'b1,1'b0,1'b0,1'b0}, // R6
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b1,1'b0,1'b1}, // R6
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,16'h0004,1'b1,2'd1,1'b0,1'b0,1'b0,1'b0}, // R5
        '{1'b1,16'h0004,1'b0,1'b0,1'b0,1'b0,16'h0004,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R5
        '{1'b1,16'h0000,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R5
        '{1'b1,16'h0010,1'b0,1'b0,1'b0,1'b0,16'h0010,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R11
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,16'h0010,1'b1,2'd2,1'b0,1'b0,1'b0,1'b0}, // R11
        '{1'b1,16'h0011,1'b0,1'b0,1'b0,1'b0,16'h0012,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R2
        '{1'b0,16'h0000,1'b0,1'b0,1'b0,1'b1,16'h0030,1'b0,2'd0,1'b0,1'b0,1'b1,1'b0}, // R12
        '{1'b1,16'h0000,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R12
        '{1'b1,16'h0008,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R10
        '{1'b1,16'h0001,1'b0,1'b0,1'b0,1'b0,16'h0002,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R2
        '{1'b1,16'h0009,1'b0,1'b0,1'b0,1'b0,16'h0002,1'b0,2'd0,1'b0,1'b0,1'b1,1'b0}, // R10
        '{1'b1,16'h0008,1'b0,1'b0,1'b0,1'b0,16'h0000,1'b0,2'd0,1'b0,1'b0,1'b1,1'b0}, // R10
        '{1'b1,16'h4000,1'b0,1'b0,1'b0,1'b0,16'h4000,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R14
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,16'h4004,1'b1,2'd3,1'b0,1'b0,1'b0,1'b0}, // R5
        '{1'b1,16'h4011,1'b0,1'b0,1'b0,1'b0,16'h4012,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R5
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,16'h4012,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0}, // R11
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,1'b0,16'h4012,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R7
        '{1'b0,16'h0000,1'b0,1'b1,1'b0,1'b0,16'h4010,1'b0,2'd0,1'b0,1'b1,1'b0,1'b1}, // R7
        '{1'b1,16'h0801,1'b0,1'b0,1'b0,1'b0,16'h0802,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R8
        '{1'b0,16'h0000,1'b0,1'b1,1'b0,1'b0,16'h0800,1'b0,2'd0,1'b0,1'b1,1'b0,1'b1}, // R8
        '{1'b0,16'h0000,1'b0,1'b0,1'b1,1'b0,16'h0800,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R8
        '{1'b1,16'h0801,1'b0,1'b0,1'b0,1'b0,16'h0802,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R8
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,16'h0802,1'b1,2'd0,1'b1,1'b0,1'b0,1'b0}, // R8
        '{1'b1,16'h0840,1'b0,1'b0,1'b0,1'b0,16'h0802,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R13
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,16'h0802,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0}, // R13
        '{1'b1,16'h0840,1'b0,1'b1,1'b0,1'b0,16'h0800,1'b0,2'd0,1'b0,1'b1,1'b0,1'b1}, // R13
        '{1'b1,16'h0001,1'b0,1'b0,1'b0,1'b0,16'h0002,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R13
        '{1'b0,16'h0000,1'b1,1'b0,1'b0,1'b0,16'h0002,1'b1,2'd0,1'b0,1'b0,1'b0,1'b0}, // R13
        '{1'b1,16'hFCC0,1'b0,1'b0,1'b0,1'b0,16'hFC02,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}, // R14
        '{1'b1,16'h0000,1'b0,1'b0,1'b0,1'b0,16'h0002,1'b0,2'd0,1'b0,1'b0,1'b0,1'b0}  // R14
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cyc(input logic wr, input logic [15:0] wd, input logic tok,
                       input logic snt, input logic ack, input logic stl);
        csr_wr = wr; csr_wdata = wd; in_token = tok;
        pkt_sent = snt; ack_rcvd = ack; stall_sent = stl;
        @(negedge clk);
        csr_wr = 1'b0; csr_wdata = '0; in_token = 1'b0;
        pkt_sent = 1'b0; ack_rcvd = 1'b0; stall_sent = 1'b0;
    endtask

    task automatic outs(input string tag, input logic [15:0] rd, input logic rel,
                        input logic fl, input logic iq);
        chk({tag, " rdata"}, csr_rdata, rd);
        chk({tag, " release"}, 16'(pkt_release), 16'(rel));
        chk({tag, " flush"}, 16'(fifo_flush), 16'(fl));
        chk({tag, " irq"}, 16'(irq), 16'(iq));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        outs("R1", 16'h0000, 1'b0, 1'b0, 1'b0);
        chk("R1 resp_valid", 16'(resp_valid), 16'h0);

        for (int i = 0; i < NV; i++) begin
            cyc(VEC[i].wr, VEC[i].wd, VEC[i].tok, VEC[i].snt, VEC[i].ack, VEC[i].stl);
            outs($sformatf("vec%0d R2-table", i), VEC[i].rd, VEC[i].rel, VEC[i].fl, VEC[i].iq);
            chk($sformatf("vec%0d R4 valid", i), 16'(resp_valid), 16'(VEC[i].rv));
            if (VEC[i].rv) begin
                chk($sformatf("vec%0d R4 kind", i), 16'(resp_kind), 16'(VEC[i].rk));
                chk($sformatf("vec%0d R4 odd", i), 16'(resp_odd), 16'(VEC[i].ro));
            end
        end

        // R3: auto-arm on reaching the maximum packet size, once per match
        cyc(1'b1, 16'h8008, 1'b0, 1'b0, 1'b0, 1'b0);
        outs("R3 setup", 16'h8000, 1'b0, 1'b1, 1'b0);
        fifo_byte_cnt = 11'd64;
        @(negedge clk);
        chk("R3 first arm", csr_rdata, 16'h8002);
        repeat (3) @(negedge clk);
        chk("R3 held match", csr_rdata, 16'h8002);
        fifo_byte_cnt = 11'd0;
        @(negedge clk);
        fifo_byte_cnt = 11'd64;
        @(negedge clk);
        chk("R3 second arm", csr_rdata, 16'h8003);
        fifo_byte_cnt = 11'd0;

        // R9: interrupt masked
        irq_en = 1'b0;
        cyc(1'b1, 16'h4000, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 setup", csr_rdata, 16'h4003);
        cyc(1'b0, 16'h0000, 1'b0, 1'b1, 1'b0, 1'b0);
        outs("R9 masked", 16'h4002, 1'b1, 1'b0, 1'b0);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 5000 && !done; c++) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule